// File: doc/BRIEF.md
# Serial Transmitter with Holding Buffer and Status Flags

This block is the transmit half of an asynchronous serial port. Software places one byte in a holding register. A frame state machine moves that byte into a shift register at a baud-tick boundary and drives it onto a single line. The line idles high, and every bit lasts one baud tick. On request the machine can instead send an all-ones idle preamble or an all-zeros break. The baud tick comes from outside the block.

Two status flags report progress: "buffer empty" and "transfer done". Each flag drives its own interrupt output, which is qualified by its own enable input. Software clears the flags with a fixed two-step sequence. First it reads the status register. Then it writes the data register, with no other register access in between. A byte written without that sequence stays in the holding register and is not sent.

The frame machine has seven states:
- `S_IDLE`: the line is high.
- `S_START`: the start bit.
- `S_DATA`: the data bits.
- `S_STOP`: the stop bit.
- `S_PRE`: the preamble.
- `S_BRK`: the low part of a break.
- `S_BRK_STOP`: the closing high bit of a break.

On a baud tick the machine moves as follows:
- `S_START` goes to `S_DATA`.
- `S_DATA` goes to `S_STOP` after its last bit.
- `S_BRK` goes to `S_BRK_STOP` after its last low tick.

A frame boundary is a tick seen in `S_IDLE`, in `S_STOP`, in `S_BRK_STOP`, or on the last tick of `S_PRE`. At a frame boundary the machine picks what to send next, in this order:
1. `S_BRK`, if a break is pending.
2. `S_PRE`, if a preamble is pending.
3. `S_START`, if a byte is pending. This also loads the byte into the shifter.
4. `S_IDLE`, if nothing is pending.

Top module: `ser_tx_unit`

## Requirements
- R1: After reset, `tx_line` is 1 and `status_byte` reads C0h.
- R2: In `status_byte`, bit 7 is the buffer-empty flag and bit 6 is the transfer-done flag. Bits 5 to 0 always read 0.
- R3: The sequence clears both flags in the cycle after the write: a `status_rd` strobe, then a later `data_wr` strobe, with neither `data_wr` nor `other_acc` strobed in between.
- R4: In each of these cases a `data_wr` loads the holding register but leaves both flags unchanged:
  - it comes without an armed status read;
  - an `other_acc` strobe came after the status read.
- R5: While the buffer-empty flag is 1, no data frame starts, and `tx_line` stays high unless a preamble or break is sent.
- R6: When the empty flag is 0 at a frame boundary with no preamble or break pending, the held byte enters the shifter on that tick. The empty flag returns to 1 in the same cycle, and the start bit appears on `tx_line` at once.
- R7: A data frame has these bits, each lasting exactly one baud-tick period:
  1. a 0 start bit;
  2. the 8 data bits, least significant first;
  3. a 1 stop bit.
- R8: A byte written (with the clear sequence) while a frame is being sent waits in the holding register. It starts on the tick that ends the current stop bit, with no idle bit in between.
- R9: The transfer-done flag becomes 1 on the tick that ends the stop bit of a data frame. If that set falls in the same cycle as a clearing write, the flag stays 1. If a buffer-empty set meets a clearing write in the same cycle, the clearing write wins.
- R10: A `preamble_req` pulse produces 10 ticks of 1 at the next frame boundary, and the transfer-done flag does not become 1 because of it.
- R11: A `break_req` pulse produces 10 ticks of 0 followed by one tick of 1, and the transfer-done flag does not become 1 because of it.
- R12: Requests are held until a frame boundary, where break goes before preamble, and preamble goes before a pending byte.
- R13: `irq_tx` equals the empty flag ANDed with `tdre_ie`. `irq_tc` equals the done flag ANDed with `tc_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_rd | input | 1 | Status register read strobe; arms the clear sequence |
| data_wr | input | 1 | Data register write strobe |
| other_acc | input | 1 | Strobe for any other register access; disarms the sequence |
| wr_data | input | 8 | Byte written with `data_wr` |
| tdre_ie | input | 1 | Enable for the buffer-empty interrupt |
| tc_ie | input | 1 | Enable for the transfer-done interrupt |
| preamble_req | input | 1 | Pulse requesting an idle preamble |
| break_req | input | 1 | Pulse requesting a break |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| status_byte | output | 8 | Status register contents |
| tx_line | output | 1 | Serial output line |
| irq_tx | output | 1 | Buffer-empty interrupt |
| irq_tc | output | 1 | Transfer-done interrupt |

## Verification
A wrong frame state or bit count shows on `tx_line` within one baud period. It appears as a misplaced start bit, a shifted data bit, or a stop bit of the wrong length. A lost or stale arm of the clear sequence shows in `status_byte` one cycle after the data write. A wrongly set done flag after a preamble or break shows on `status_byte` bit 6 and on `irq_tc` in the cycle after the closing tick. The bench compares every output on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_START    = 3'd1,
        S_DATA     = 3'd2,
        S_STOP     = 3'd3,
        S_PRE      = 3'd4,
        S_BRK      = 3'd5,
        S_BRK_STOP = 3'd6
    } tx_state_e;

    localparam int STATUS_W = 8;

endpackage

// File: rtl/ser_tx_flags.sv
module ser_tx_flags
    import ser_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                status_rd,
    input  logic                data_wr,
    input  logic                other_acc,
    input  logic [DW-1:0]       wr_data,
    input  logic                load_fire,
    input  logic                data_done,
    input  logic                tdre_ie,
    input  logic                tc_ie,
    output logic [DW-1:0]       hold_data,
    output logic                pending,
    output logic [STATUS_W-1:0] status_byte,
    output logic                irq_tx,
    output logic                irq_tc
);

    logic empty_q;
    logic done_q;
    logic armed_q;
    logic clr;

    // a write clears the flags only when a status read armed the sequence
    assign clr = data_wr & armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q   <= 1'b1;
            done_q    <= 1'b1;
            armed_q   <= 1'b0;
            hold_data <= '0;
        end else begin
            if (status_rd)
                armed_q <= 1'b1;
            else if (data_wr || other_acc)
                armed_q <= 1'b0;

            if (data_wr)
                hold_data <= wr_data;

            if (clr)
                empty_q <= 1'b0;
            else if (load_fire)
                empty_q <= 1'b1;

            if (data_done)
                done_q <= 1'b1;
            else if (clr)
                done_q <= 1'b0;
        end
    end

    assign pending     = ~empty_q;
    assign status_byte = {empty_q, done_q, {(STATUS_W-2){1'b0}}};
    assign irq_tx      = empty_q & tdre_ie;
    assign irq_tc      = done_q & tc_ie;

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
    import ser_tx_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PRE_TICKS = 10,
    parameter int BRK_TICKS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          pending,
    input  logic [DW-1:0] hold_data,
    input  logic          pre_req,
    input  logic          brk_req,
    output logic          tx_line,
    output logic          load_fire,
    output logic          data_done,
    output tx_state_e     state_o
);

    localparam int MAXA = (DW > PRE_TICKS) ? DW : PRE_TICKS;
    localparam int MAXC = (MAXA > BRK_TICKS) ? MAXA : BRK_TICKS;
    localparam int CW   = $clog2(MAXC + 1);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shf_q;
    logic          pre_pend_q, brk_pend_q;
    logic          pre_any, brk_any;
    logic          take_pre, take_brk;
    logic          at_boundary;

    assign pre_any = pre_pend_q | pre_req;
    assign brk_any = brk_pend_q | brk_req;

    assign at_boundary = baud_tick &&
        (state_q == S_IDLE || state_q == S_STOP || state_q == S_BRK_STOP ||
         (state_q == S_PRE && cnt_q == CW'(PRE_TICKS - 1)));

    // next-state selection
    always_comb begin
        state_d   = state_q;
        load_fire = 1'b0;
        data_done = 1'b0;
        take_pre  = 1'b0;
        take_brk  = 1'b0;
        if (baud_tick) begin
            unique case (state_q)
                S_START:    state_d = S_DATA;
                S_DATA:     if (cnt_q == CW'(DW - 1)) state_d = S_STOP;
                S_BRK:      if (cnt_q == CW'(BRK_TICKS - 1)) state_d = S_BRK_STOP;
                S_IDLE, S_STOP, S_PRE, S_BRK_STOP: ;
                default:    state_d = S_IDLE;
            endcase
        end
        if (at_boundary) begin
            data_done = (state_q == S_STOP);
            if (brk_any) begin
                state_d  = S_BRK;
                take_brk = 1'b1;
            end else if (pre_any) begin
                state_d  = S_PRE;
                take_pre = 1'b1;
            end else if (pending) begin
                state_d   = S_START;
                load_fire = 1'b1;
            end else begin
                state_d = S_IDLE;
            end
        end
    end

    // state register, bit counter, shifter, request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            cnt_q      <= '0;
            shf_q      <= '0;
            pre_pend_q <= 1'b0;
            brk_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pre_pend_q <= take_pre ? 1'b0 : pre_any;
            brk_pend_q <= take_brk ? 1'b0 : brk_any;
            if (at_boundary || (baud_tick && state_d != state_q))
                cnt_q <= '0;
            else if (baud_tick && (state_q == S_DATA || state_q == S_PRE || state_q == S_BRK))
                cnt_q <= cnt_q + 1'b1;
            if (load_fire)
                shf_q <= hold_data;
            else if (baud_tick && state_q == S_DATA)
                shf_q <= shf_q >> 1;
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            S_START:    tx_line = 1'b0;
            S_DATA:     tx_line = shf_q[0];
            S_BRK:      tx_line = 1'b0;
            S_IDLE, S_STOP, S_PRE, S_BRK_STOP: tx_line = 1'b1;
            default:    tx_line = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ser_tx_unit.sv
module ser_tx_unit
    import ser_tx_pkg::*;
#(
    parameter int PRE_TICKS = 10,
    parameter int BRK_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       status_rd,
    input  logic       data_wr,
    input  logic       other_acc,
    input  logic [7:0] wr_data,
    input  logic       tdre_ie,
    input  logic       tc_ie,
    input  logic       preamble_req,
    input  logic       break_req,
    input  logic       baud_tick,
    output logic [7:0] status_byte,
    output logic       tx_line,
    output logic       irq_tx,
    output logic       irq_tc
);

    localparam int DW = 8;

    logic [DW-1:0] hold_data;
    logic          pending;
    logic          load_fire;
    logic          data_done;
    tx_state_e     fsm_state;

    ser_tx_flags #(.DW(DW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_rd   (status_rd),
        .data_wr     (data_wr),
        .other_acc   (other_acc),
        .wr_data     (wr_data),
        .load_fire   (load_fire),
        .data_done   (data_done),
        .tdre_ie     (tdre_ie),
        .tc_ie       (tc_ie),
        .hold_data   (hold_data),
        .pending     (pending),
        .status_byte (status_byte),
        .irq_tx      (irq_tx),
        .irq_tc      (irq_tc)
    );

    ser_tx_frame #(.DW(DW), .PRE_TICKS(PRE_TICKS), .BRK_TICKS(BRK_TICKS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .pending   (pending),
        .hold_data (hold_data),
        .pre_req   (preamble_req),
        .brk_req   (break_req),
        .tx_line   (tx_line),
        .load_fire (load_fire),
        .data_done (data_done),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/ser_tx_checker.sv
module ser_tx_checker
    import ser_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       data_wr,
    input logic       tc_ie,
    input logic [7:0] status_byte,
    input logic       irq_tc,
    input tx_state_e  fsm_state
);

    assert_empty_rise_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[7]) |-> fsm_state == S_START);

    assert_start_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_START && $past(fsm_state) != S_START) |-> !$past(status_byte[7]));

    assert_done_rise_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[6]) |-> $past(fsm_state) == S_STOP);

    assert_done_fall_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_byte[6]) |-> $past(data_wr));

    assert_state_moves_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != $past(fsm_state)) |-> $past(baud_tick));

    assert_no_done_after_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_state) == S_BRK_STOP && fsm_state != S_BRK_STOP) |-> !$rose(status_byte[6]));

    assert_done_irq_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tc |-> tc_ie);

endmodule

bind ser_tx_unit ser_tx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick),
    .data_wr     (data_wr),
    .tc_ie       (tc_ie),
    .status_byte (status_byte),
    .irq_tc      (irq_tc),
    .fsm_state   (fsm_state)
);

// File: tb/ser_tx_unit_tb.sv
module ser_tx_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       status_rd = 1'b0, data_wr = 1'b0, other_acc = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tdre_ie = 1'b0, tc_ie = 1'b0;
    logic       preamble_req = 1'b0, break_req = 1'b0, baud_tick = 1'b0;
    logic [7:0] status_byte;
    logic       tx_line, irq_tx, irq_tc;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R1";

    // behavioural reference state
    int   q[$];
    bit   m_empty = 1, m_done = 1, m_armed = 0, kind_data = 0, bp = 0, pp = 0;
    logic [7:0] m_hold = 8'h00;

    always #5 clk = ~clk;

    ser_tx_unit u_dut (
        .clk (clk), .rst_n (rst_n), .status_rd (status_rd), .data_wr (data_wr),
        .other_acc (other_acc), .wr_data (wr_data), .tdre_ie (tdre_ie), .tc_ie (tc_ie),
        .preamble_req (preamble_req), .break_req (break_req), .baud_tick (baud_tick),
        .status_byte (status_byte), .tx_line (tx_line), .irq_tx (irq_tx), .irq_tc (irq_tc)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_step();
        bit clr = 0, set_empty = 0, set_done = 0;
        bp = bp | break_req;
        pp = pp | preamble_req;
        if (baud_tick) begin
            if (q.size() > 0) begin
                void'(q.pop_front());
                if (q.size() == 0 && kind_data) set_done = 1;
            end
            if (q.size() == 0) begin
                kind_data = 0;
                if (bp) begin
                    bp = 0;
                    repeat (10) q.push_back(0);
                    q.push_back(1);
                end else if (pp) begin
                    pp = 0;
                    repeat (10) q.push_back(1);
                end else if (!m_empty) begin
                    q.push_back(0);
                    for (int i = 0; i < 8; i++) q.push_back(int'(m_hold[i]));
                    q.push_back(1);
                    kind_data = 1;
                    set_empty = 1;
                end
            end
        end
        clr = data_wr && m_armed;
        if (data_wr) m_hold = wr_data;
        if (clr) m_empty = 0; else if (set_empty) m_empty = 1;
        if (set_done) m_done = 1; else if (clr) m_done = 0;
        if (status_rd) m_armed = 1; else if (data_wr || other_acc) m_armed = 0;
    endtask

    task automatic compare();
        int exp_line;
        exp_line = (q.size() > 0) ? q[0] : 1;
        check(tag, int'(status_byte), int'({m_empty, m_done, 6'b0}), "status_byte");
        check(tag, int'(tx_line), exp_line, "tx_line");
        check("R13", int'(irq_tx), int'(m_empty & tdre_ie), "irq_tx");
        check("R13", int'(irq_tc), int'(m_done & tc_ie), "irq_tc");
    endtask

    task automatic step();
        baud_tick = (cyc % 4 == 3);
        model_step();
        @(posedge clk);
        #1;
        cyc++;
        compare();
        status_rd = 0; data_wr = 0; other_acc = 0; preamble_req = 0; break_req = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic rd_status();
        status_rd = 1;
        step();
    endtask

    task automatic wr_byte(input logic [7:0] d);
        data_wr = 1;
        wr_data = d;
        step();
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tag = "R1";
        check("R1", int'(status_byte), 'hC0, "status after reset");
        check("R1", int'(tx_line), 1, "line after reset");
        rst_n = 1;
        run(6);
        tag = "R2";
        check("R2", int'(status_byte[5:0]), 0, "low status bits");

        // write without and with an interrupted sequence: flags stay, nothing sent
        tag = "R4";
        wr_byte(8'hA5);
        run(5);
        rd_status();
        other_acc = 1; step();
        wr_byte(8'h3C);
        tag = "R5";
        run(20);
        check("R5", int'(tx_line), 1, "line idle while empty flag set");

        // proper clear sequence, then a full data frame
        tag = "R3";
        rd_status();
        run(2);
        wr_byte(8'h3C);
        check("R3", int'(status_byte), 'h00, "flags after clear sequence");
        tag = "R6";
        run(6);
        tag = "R7";
        run(40);
        tag = "R9";
        run(6);

        // interrupt enables
        tag = "R13";
        tdre_ie = 1; tc_ie = 1;
        run(3);
        rd_status();
        wr_byte(8'h81);
        run(10);

        // second byte written while the first is on the line
        tag = "R8";
        rd_status();
        wr_byte(8'h7E);
        run(100);

        // preamble with a pending byte behind it
        tag = "R10";
        preamble_req = 1; step();
        rd_status();
        wr_byte(8'hC3);
        run(100);

        // break with a pending byte behind it
        tag = "R11";
        break_req = 1; step();
        rd_status();
        wr_byte(8'h99);
        run(110);

        // both requests at once plus a pending byte, issued mid-frame
        tag = "R12";
        rd_status();
        wr_byte(8'h55);
        run(9);
        preamble_req = 1; break_req = 1; step();
        rd_status();
        wr_byte(8'hE1);
        run(200);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule